// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits behind an asynchronous parallel memory bus (active-low chip enable, output enable and write enable, plus address, data and a flag that reports whether the programming supply is at its high level). It samples the write strobe with the system clock and turns each completed write cycle into a command. Two commands are decoded. The first is a bulk erase, written as the same erase code in two back-to-back write cycles. The second is an erase verify, which names an address and returns the word stored there on the following read cycle.

The erase is timed by an internal countdown whose length is derived from the clock frequency and a nominal erase time (9.5 ms by default). When the countdown expires, every word of a small behavioural storage model is set to the erased value in one step. During the countdown a busy flag is raised, and every bus write is dropped. The storage model comes out of reset with a computed, non-erased pattern, so that an erase leaves a visible change.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, busy_o and data_oe_o are low and the word at address a reads, through erase verify, as a XOR RESET_SEED (default 0xA5).
- R2: A write cycle counts only while ce_ni is low. The address is taken at the cycle where we_ni goes low, and the command byte is taken at the cycle where we_ni goes back high. An address change after the falling edge does not alter the verify address.
- R3: Command 0x20 followed directly by a second accepted 0x20 starts the erase on that second rising edge. From the next cycle on, busy_o is high for exactly ERASE_CYCLES = CLK_KHZ*ERASE_US/1000 cycles.
- R4: When the erase countdown ends, every address reads 0xFF through erase verify.
- R5: If the accepted write that follows a first 0x20 carries any other code, the controller returns to idle. Nothing is erased, and that second code is not executed.
- R6: An accepted 0xA0 enters verify mode with the latched address. While in verify mode with ce_ni and oe_ni both low, data_oe_o is 1 and data_o holds the stored word. Any later accepted write that is not 0xA0 leaves verify mode.
- R7: data_oe_o is 0 whenever ce_ni or oe_ni is high, or whenever the controller is not in verify mode. data_o is 0 whenever data_oe_o is 0.
- R8: A write whose rising edge occurs while vpp_hi_i is low is ignored. This includes a pending first erase cycle, which stays armed.
- R9: A write whose rising edge occurs while busy_o is high is ignored. This includes a rising edge on the same clock edge at which the countdown expires.
- R10: A write cycle with ce_ni high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write strobe, active low |
| vpp_hi_i | input | 1 | Programming supply at high level |
| addr_i | input | AW | Bus address |
| data_i | input | DW | Bus write data |
| data_o | output | DW | Read data, 0 when not driven |
| data_oe_o | output | 1 | Data bus drive enable (bus released when low) |
| busy_o | output | 1 | Erase countdown running |

## Verification
The expiry of the erase countdown and the arrival of a new command can land on the same clock edge. On that edge the array is cleared and busy drops, while the rising write strobe must still be judged against the busy state from before the edge. The bench times a 0xA0 write so that its rising strobe is sampled exactly on the expiry edge, and then requires that no verify mode is entered (no drive on a read). A later verify must then see 0xFF. The reference model also tracks the address latch, which is still loaded by a strobe falling during busy, and checks busy, drive enable and read data on every clock.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_VERIFY = 2'd2
  } fci_state_e;

  localparam logic [7:0] OP_ERASE  = 8'h20;
  localparam logic [7:0] OP_VERIFY = 8'hA0;
endpackage

// File: rtl/fci_we_edge.sv
module fci_we_edge #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_ni,
  input  logic          ce_ni,
  input  logic [AW-1:0] addr_i,
  output logic          rise_o,
  output logic [AW-1:0] addr_lat_o
);
  logic we_q;
  logic fall;

  assign fall   = we_q & ~we_ni;
  assign rise_o = ~we_q & we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q       <= 1'b1;
      addr_lat_o <= '0;
    end else begin
      we_q <= we_ni;
      if (fall && !ce_ni) addr_lat_o <= addr_i;
    end
  end
endmodule

// File: rtl/fci_erase_timer.sv
module fci_erase_timer #(
  parameter int CYCLES = 9500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  assign done_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fci_array.sv
module fci_array #(
  parameter int             AW   = 4,
  parameter int             DW   = 8,
  parameter logic [DW-1:0]  SEED = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          erase_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(i) ^ SEED;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int            AW         = 4,
  parameter int            DW         = 8,
  parameter int            CLK_KHZ    = 1000,
  parameter int            ERASE_US   = 9500,
  parameter logic [DW-1:0] RESET_SEED = DW'(8'hA5)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic          vpp_hi_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          busy_o
);
  localparam int ERASE_CYCLES = CLK_KHZ * ERASE_US / 1000;

  fci_state_e    state_q;
  logic          we_rise;
  logic [AW-1:0] addr_lat;
  logic [AW-1:0] vaddr_q;
  logic          accept;
  logic          is_erase, is_verify;
  logic          erase_start, erase_done;
  logic [DW-1:0] rd_data;

  fci_we_edge #(.AW(AW)) u_edge (
    .clk_i, .rst_ni, .we_ni, .ce_ni, .addr_i,
    .rise_o(we_rise), .addr_lat_o(addr_lat)
  );

  assign is_erase    = (data_i == DW'(OP_ERASE));
  assign is_verify   = (data_i == DW'(OP_VERIFY));
  assign accept      = we_rise && !ce_ni && vpp_hi_i && !busy_o;
  assign erase_start = accept && (state_q == ST_ARMED) && is_erase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vaddr_q <= '0;
    end else if (accept) begin
      if (state_q == ST_ARMED) begin
        state_q <= ST_IDLE;  // second cycle: erase or abort
      end else if (is_erase) begin
        state_q <= ST_ARMED;
      end else if (is_verify) begin
        state_q <= ST_VERIFY;
        vaddr_q <= addr_lat;
      end else begin
        state_q <= ST_IDLE;
      end
    end
  end

  fci_erase_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(erase_start), .busy_o, .done_o(erase_done)
  );

  fci_array #(.AW(AW), .DW(DW), .SEED(RESET_SEED)) u_array (
    .clk_i, .rst_ni, .erase_i(erase_done),
    .rd_addr_i(vaddr_q), .rd_data_o(rd_data)
  );

  assign data_oe_o = (state_q == ST_VERIFY) && !ce_ni && !oe_ni;
  assign data_o    = data_oe_o ? rd_data : '0;
endmodule

// File: rtl/fci_checker.sv
module fci_checker #(
  parameter int DW           = 8,
  parameter int ERASE_CYCLES = 9500
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_ni,
  input logic          oe_ni,
  input logic          we_ni,
  input logic          vpp_hi_i,
  input logic [DW-1:0] data_i,
  input logic [DW-1:0] data_o,
  input logic          data_oe_o,
  input logic          busy_o
);
  int unsigned busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len <= 0;
    else if (busy_o) busy_len <= busy_len + 1;
    else             busy_len <= 0;
  end

  assert_oe_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!ce_ni && !oe_ni));

  assert_quiet_bus_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));

  assert_no_read_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !data_oe_o);

  assert_busy_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(we_ni) && $past(vpp_hi_i) && !$past(ce_ni)
                       && $past(data_i) == DW'(8'h20)));

  assert_busy_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_len == ERASE_CYCLES));

  assert_no_vpp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vpp_hi_i && !busy_o) |=> !busy_o);
endmodule

bind flash_cmd_ctrl fci_checker #(.DW(DW), .ERASE_CYCLES(ERASE_CYCLES)) u_fci_checker (
  .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .vpp_hi_i,
  .data_i, .data_o, .data_oe_o, .busy_o
);

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int ERASE_N = 38;  // 4 kHz * 9500 us / 1000

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, vpp = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, busy;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_cmd_ctrl #(.AW(AW), .DW(DW), .CLK_KHZ(4), .ERASE_US(9500)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .vpp_hi_i(vpp), .addr_i(addr), .data_i(din), .data_o(dout),
    .data_oe_o(dout_en), .busy_o(busy)
  );

  // reference model: 0 idle, 1 armed, 2 verify
  int m_state, m_cnt, m_addr_lat, m_vaddr;
  bit m_weq, m_run;
  int m_mem[DEPTH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_addr_lat = 0; m_vaddr = 0; m_weq = 1; m_run = 0;
      for (int i = 0; i < DEPTH; i++) m_mem[i] = i ^ 'hA5;
    end else begin
      bit rise, fall, acc;
      rise = !m_weq && we_n;
      fall = m_weq && !we_n;
      acc  = rise && !ce_n && vpp && !m_run;
      if (fall && !ce_n) m_addr_lat = int'(addr);
      if (m_run) begin
        if (m_cnt == 0) begin
          m_run = 0;
          for (int i = 0; i < DEPTH; i++) m_mem[i] = 'hFF;
        end else m_cnt--;
      end
      if (acc) begin
        if (m_state == 1) begin
          if (din == 8'h20) begin m_run = 1; m_cnt = ERASE_N - 1; end
          m_state = 0;
        end else if (din == 8'h20) m_state = 1;
        else if (din == 8'hA0) begin m_state = 2; m_vaddr = m_addr_lat; end
        else m_state = 0;
      end
      m_weq = we_n;
    end
  end

  int busy_seen = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_oe;
      int e_d;
      e_oe = (m_state == 2) && !ce_n && !oe_n;
      e_d  = e_oe ? m_mem[m_vaddr] : 0;
      if (busy) busy_seen++;
      checks += 3;
      if (busy !== m_run) begin
        errors++; $display("FAIL R3 busy_o act=%0b exp=%0b t=%0t", busy, m_run, $time);
      end
      if (dout_en !== e_oe) begin
        errors++; $display("FAIL R7 data_oe_o act=%0b exp=%0b t=%0t", dout_en, e_oe, $time);
      end
      if (int'(dout) !== e_d) begin
        errors++; $display("FAIL R6 data_o act=%0h exp=%0h t=%0t", dout, e_d, $time);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input int a, input int d, input bit v = 1, input bit c = 0);
    step(); ce_n = c; vpp = v; addr = AW'(a); we_n = 1'b0;
    step(); din = DW'(d); addr = AW'(~a); we_n = 1'b1;
    step(); ce_n = 1'b1;
    step();
  endtask

  task automatic rd(input string tag, input int exp_en, input int exp_d);
    step(); ce_n = 1'b0; oe_n = 1'b0; #2;
    chk({tag, " oe"}, int'(dout_en), exp_en);
    chk({tag, " data"}, int'(dout), exp_d);
    step(); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    #2;
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 oe after reset", int'(dout_en), 0);

    // R1 R2 R6: verify address 3, address changed after fall
    wr(3, 'hA0);
    rd("R2 R1 verify addr3", 1, 3 ^ 'hA5);

    // R7: only one of the enables low
    step(); ce_n = 1'b0; oe_n = 1'b1; #2;
    chk("R7 oe high", int'(dout_en), 0);
    step(); ce_n = 1'b1; oe_n = 1'b0; #2;
    chk("R7 ce high", int'(dout_en), 0);
    step(); oe_n = 1'b1;

    // R8: no programming level
    wr(5, 'hA0, 0);
    rd("R8 vpp low ignored", 1, 3 ^ 'hA5);

    // R10: chip enable high
    wr(7, 'hA0, 1, 1);
    rd("R10 ce high ignored", 1, 3 ^ 'hA5);

    // R5: abort with other code, then with verify code
    wr(0, 'h20);
    wr(0, 'h55);
    rd("R5 abort idle", 0, 0);
    wr(0, 'h20);
    wr(1, 'hA0);
    rd("R5 verify code not run", 0, 0);
    wr(9, 'hA0);
    rd("R5 no erase", 1, 9 ^ 'hA5);

    // R8 armed stays armed, then R3 erase
    wr(0, 'h20);
    wr(0, 'h20, 0);
    chk("R8 armed no start", int'(busy), 0);
    busy_seen = 0;
    wr(0, 'h20);
    chk("R3 busy after start", int'(busy), 1);

    // R9: command while busy
    wr(2, 'hA0);
    rd("R9 busy ignores write", 0, 0);

    // R9: rising strobe on the expiry edge
    step(); ce_n = 1'b0; addr = 4'd6; we_n = 1'b0;
    while (!(m_run && m_cnt == 0)) @(negedge clk);
    #1 din = 8'hA0; we_n = 1'b1;
    step(); ce_n = 1'b1;
    step(); #2;
    chk("R3 busy cleared", int'(busy), 0);
    chk("R3 busy length", busy_seen, ERASE_N);
    rd("R9 expiry edge write dropped", 0, 0);

    // R4: erased contents
    wr(4, 'hA0);
    rd("R4 addr4 erased", 1, 'hFF);
    wr(15, 'hA0);
    rd("R4 addr15 erased", 1, 'hFF);
    wr(0, 'hA0);
    rd("R4 addr0 erased", 1, 'hFF);

    // R6: leave verify mode
    wr(0, 'h00);
    rd("R6 verify exit", 0, 0);

    step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule